// File: doc/BRIEF.md
# Three-Axis Synchronized Linear Interpolator

This block turns one straight-line move into step pulses for three axes. Software or a command decoder provides a start point, an end point and a feed command, then pulses `start`. The block takes each axis distance as a step count at one step per basic length unit. The longest axis sets the length of the move.

A rate generator derives a master tick from the ratio of the feed command to the maximum feed. On every tick, each axis adds its own distance to a private accumulator. An axis steps when its accumulator reaches the longest distance. All three axes run in parallel under the same ticks, so every axis fires its last pulse in the same clock. `done` then marks the end of the move.

The controller is a four-state machine:
- `ST_IDLE` waits for `start`. It goes to `ST_RUN` for a move of non-zero length, and straight to `ST_DONE` for a zero-length move.
- `ST_RUN` follows the master ticks. It goes to `ST_DRAIN` on the tick that carries the longest axis's last step.
- `ST_DRAIN` holds for one clock while that last step pulse is driven, then goes to `ST_DONE`.
- `ST_DONE` raises `done` for one clock and returns to `ST_IDLE`.

Top module: `lin3_interp`

## Requirements
- R1: Each axis emits exactly |to − from| step pulses per move, where the coordinates are unsigned integers.
- R2: Each direction output is 1 when that axis's end coordinate is greater than its start coordinate, and 0 otherwise. It is latched when `start` is accepted and held until the next accepted move.
- R3: The longest axis steps on every master tick, and every axis with a non-zero distance emits its last pulse in the same clock cycle.
- R4: With the defaults FMAX = 1000 and TICK_DIV = 4, the master tick period is 4000/feed clocks when 4000 is a multiple of the feed. Counting the accepting clock edge as edge 0, `done` rises after edge P·L + 1, where P is that period and L is the longest distance.
- R5: A feed above FMAX is treated as FMAX. A feed of 0 is treated as 1.
- R6: `done` is high for exactly one cycle, the cycle after the last step pulse. `busy` is high from the accepting edge through the `done` cycle and low afterwards.
- R7: A `start` pulse while `busy` is high is ignored: the step counts, directions and timing of the running move are unchanged.
- R8: A move whose three distances are all zero emits no pulses and raises `done` right after the accepting edge (edge 0).
- R9: During reset and right after it, `busy`, `done`, every step output and every direction output are 0. A reset in the middle of a move returns all of them to 0.
- R10: Every step pulse is exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Move request strobe |
| x_from | input | COORD_W | X start coordinate |
| y_from | input | COORD_W | Y start coordinate |
| z_from | input | COORD_W | Z start coordinate |
| x_to | input | COORD_W | X end coordinate |
| y_to | input | COORD_W | Y end coordinate |
| z_to | input | COORD_W | Z end coordinate |
| feed | input | FEED_W | Feed command in the same units as FMAX |
| step_x | output | 1 | X step pulse |
| step_y | output | 1 | Y step pulse |
| step_z | output | 1 | Z step pulse |
| dir_x | output | 1 | X direction (1 = increasing) |
| dir_y | output | 1 | Y direction (1 = increasing) |
| dir_z | output | 1 | Z direction (1 = increasing) |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion flag |

## Verification
- **Step pulses:** a step pulse appears on the edge that closes the tick cycle, so the k-th tick of a move shows up after edge P·k. The last step therefore falls at edge P·L.
- **Done timing:** `done` follows one edge after the last step, at edge P·L + 1. For a zero-length move it appears at edge 0.
- **How the bench measures:** it counts clock edges from the accepting edge and samples at the falling edge. It records the edge index of each axis's last pulse and of `done`, then compares them against these formulas.
- **After done:** it also looks one cycle past `done` to confirm that both `done` and `busy` have dropped.

// File: rtl/lin3_pkg.sv
package lin3_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DRAIN,
        ST_DONE
    } lin3_state_e;
endpackage

// File: rtl/lin3_rate_gen.sv
// Master tick generator: fractional accumulator, one tick per TH/feed clocks.
module lin3_rate_gen #(
    parameter int FEED_W   = 16,
    parameter int FMAX     = 1000,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [FEED_W-1:0] feed,
    output logic              tick
);
    localparam int TH    = FMAX * TICK_DIV;
    localparam int ACC_W = $clog2(TH + FMAX + 1) + 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        sum  = acc_q + ACC_W'(feed);
        tick = en && (sum >= ACC_W'(TH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= tick ? (sum - ACC_W'(TH)) : sum;
        end
    end
endmodule

// File: rtl/lin3_axis_dda.sv
// One axis of the distributor: adds its distance per tick, steps on reaching span.
module lin3_axis_dda #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         tick,
    input  logic [W-1:0] mag,
    input  logic [W-1:0] span,
    output logic         step
);
    logic [W:0] acc_q;
    logic [W:0] sum;
    logic       hit;

    always_comb begin
        sum = acc_q + {1'b0, mag};
        hit = sum >= {1'b0, span};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            step  <= 1'b0;
        end else if (load) begin
            acc_q <= '0;
            step  <= 1'b0;
        end else if (tick) begin
            step  <= hit;
            acc_q <= hit ? (sum - {1'b0, span}) : sum;
        end else begin
            step  <= 1'b0;
        end
    end
endmodule

// File: rtl/lin3_interp.sv
module lin3_interp #(
    parameter int COORD_W  = 16,
    parameter int FEED_W   = 16,
    parameter int FMAX     = 1000,
    parameter int TICK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [COORD_W-1:0] x_from,
    input  logic [COORD_W-1:0] y_from,
    input  logic [COORD_W-1:0] z_from,
    input  logic [COORD_W-1:0] x_to,
    input  logic [COORD_W-1:0] y_to,
    input  logic [COORD_W-1:0] z_to,
    input  logic [FEED_W-1:0]  feed,
    output logic               step_x,
    output logic               step_y,
    output logic               step_z,
    output logic               dir_x,
    output logic               dir_y,
    output logic               dir_z,
    output logic               busy,
    output logic               done
);
    import lin3_pkg::*;

    localparam int NAX = 3;

    initial begin
        if (TICK_DIV < 2) $error("TICK_DIV must be at least 2");
    end

    logic [COORD_W-1:0] from_a [NAX];
    logic [COORD_W-1:0] to_a   [NAX];
    logic [COORD_W-1:0] mag_d  [NAX];
    logic [COORD_W-1:0] mag_q  [NAX];
    logic [NAX-1:0]     dir_d, dir_q, step_a;
    logic [COORD_W-1:0] span_d, span_q, tick_cnt_q;
    logic [FEED_W-1:0]  feed_c, feed_q;
    logic               accept, tick, last_tick;
    lin3_state_e        state_q, state_d;

    assign from_a[0] = x_from;
    assign from_a[1] = y_from;
    assign from_a[2] = z_from;
    assign to_a[0]   = x_to;
    assign to_a[1]   = y_to;
    assign to_a[2]   = z_to;

    assign accept = start && (state_q == ST_IDLE);

    // Per-axis magnitude and sign, plus the per-axis distributor.
    for (genvar i = 0; i < NAX; i++) begin : g_axis
        always_comb begin
            dir_d[i] = to_a[i] > from_a[i];
            mag_d[i] = dir_d[i] ? (to_a[i] - from_a[i]) : (from_a[i] - to_a[i]);
        end

        lin3_axis_dda #(.W(COORD_W)) u_dda (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (accept),
            .tick  (tick),
            .mag   (mag_q[i]),
            .span  (span_q),
            .step  (step_a[i])
        );
    end

    always_comb begin
        span_d = '0;
        for (int i = 0; i < NAX; i++) begin
            if (mag_d[i] > span_d) span_d = mag_d[i];
        end
    end

    always_comb begin
        if (feed == '0)                      feed_c = FEED_W'(1);
        else if (feed > FEED_W'(FMAX))       feed_c = FEED_W'(FMAX);
        else                                 feed_c = feed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NAX; i++) mag_q[i] <= '0;
            dir_q  <= '0;
            span_q <= '0;
            feed_q <= FEED_W'(1);
        end else if (accept) begin
            for (int i = 0; i < NAX; i++) mag_q[i] <= mag_d[i];
            dir_q  <= dir_d;
            span_q <= span_d;
            feed_q <= feed_c;
        end
    end

    lin3_rate_gen #(
        .FEED_W   (FEED_W),
        .FMAX     (FMAX),
        .TICK_DIV (TICK_DIV)
    ) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (state_q == ST_RUN),
        .feed  (feed_q),
        .tick  (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tick_cnt_q <= '0;
        else if (accept)  tick_cnt_q <= '0;
        else if (tick)    tick_cnt_q <= tick_cnt_q + 1'b1;
    end

    assign last_tick = tick && (tick_cnt_q == span_q - 1'b1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = (span_d == '0) ? ST_DONE : ST_RUN;
            ST_RUN:   if (last_tick) state_d = ST_DRAIN;
            ST_DRAIN: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy   = (state_q != ST_IDLE);
        done   = (state_q == ST_DONE);
        step_x = step_a[0];
        step_y = step_a[1];
        step_z = step_a[2];
        dir_x  = dir_q[0];
        dir_y  = dir_q[1];
        dir_z  = dir_q[2];
    end
endmodule

// File: rtl/lin3_interp_chk.sv
module lin3_interp_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic step_x,
    input logic step_y,
    input logic step_z,
    input logic dir_x,
    input logic dir_y,
    input logic dir_z,
    input logic busy,
    input logic done
);
    AST_STEP_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (step_x || step_y || step_z) |-> busy); // R6
    AST_STEP_NARROW_X: assert property (@(posedge clk) disable iff (!rst_n)
        step_x |=> !step_x); // R10
    AST_STEP_NARROW_Y: assert property (@(posedge clk) disable iff (!rst_n)
        step_y |=> !step_y); // R10
    AST_STEP_NARROW_Z: assert property (@(posedge clk) disable iff (!rst_n)
        step_z |=> !step_z); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(step_x || step_y || step_z)); // R6
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R6
    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable({dir_x, dir_y, dir_z})); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !done) |=> busy); // R7
endmodule

bind lin3_interp lin3_interp_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .step_x (step_x),
    .step_y (step_y),
    .step_z (step_z),
    .dir_x  (dir_x),
    .dir_y  (dir_y),
    .dir_z  (dir_z),
    .busy   (busy),
    .done   (done)
);

// File: tb/lin3_interp_tb_top.sv
`timescale 1ns/1ps
module lin3_interp_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] x_from = '0, y_from = '0, z_from = '0;
    logic [15:0] x_to = '0, y_to = '0, z_to = '0;
    logic [15:0] feed = 16'd1000;
    logic        step_x, step_y, step_z, dir_x, dir_y, dir_z, busy, done;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    lin3_interp dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_from(x_from), .y_from(y_from), .z_from(z_from),
        .x_to(x_to), .y_to(y_to), .z_to(z_to), .feed(feed),
        .step_x(step_x), .step_y(step_y), .step_z(step_z),
        .dir_x(dir_x), .dir_y(dir_y), .dir_z(dir_z),
        .busy(busy), .done(done)
    );

    // {x_from, y_from, z_from, x_to, y_to, z_to, feed}
    localparam int NVEC = 6;
    localparam logic [111:0] VEC [NVEC] = '{
        {16'd1,   16'd1,   16'd1,   16'd10,  16'd6,   16'd8,   16'd1000},
        {16'd10,  16'd6,   16'd8,   16'd1,   16'd1,   16'd1,   16'd400},
        {16'd5,   16'd20,  16'd3,   16'd9,   16'd2,   16'd3,   16'd500},
        {16'd0,   16'd0,   16'd0,   16'd3,   16'd3,   16'd3,   16'd2000},
        {16'd100, 16'd100, 16'd100, 16'd100, 16'd100, 16'd112, 16'd250},
        {16'd1,   16'd1,   16'd1,   16'd2,   16'd1,   16'd1,   16'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic run_move(input int sx, input int sy, input int sz,
                            input int ex, input int ey, input int ez,
                            input int f, input bit inject);
        int d[3], cnt[3], last[3];
        int len, fc, per, exp_edges, edges, done_at;
        bit seen, dir_bad, busy_bad;
        logic [2:0] exp_dir;
        d[0] = absd(sx, ex); d[1] = absd(sy, ey); d[2] = absd(sz, ez);
        exp_dir = {ez > sz, ey > sy, ex > sx};
        len = d[0];
        if (d[1] > len) len = d[1];
        if (d[2] > len) len = d[2];
        fc  = (f == 0) ? 1 : ((f > 1000) ? 1000 : f);
        per = 4000 / fc;
        exp_edges = (len == 0) ? 0 : per * len + 1;
        for (int i = 0; i < 3; i++) begin cnt[i] = 0; last[i] = -1; end
        seen = 0; dir_bad = 0; busy_bad = 0; done_at = -1; edges = 0;

        @(negedge clk);
        x_from = 16'(sx); y_from = 16'(sy); z_from = 16'(sz);
        x_to = 16'(ex); y_to = 16'(ey); z_to = 16'(ez);
        feed = 16'(f); start = 1'b1;
        @(posedge clk);
        while (!seen && edges < 20000) begin
            @(negedge clk);
            start = 1'b0;
            if (inject && edges == 5) begin   // R7: request a different move mid-run
                x_from = 16'd50; y_from = 16'd0; z_from = 16'd0;
                x_to = 16'd0; y_to = 16'd9; z_to = 16'd9; feed = 16'd1000;
                start = 1'b1;
            end
            if (step_x) begin cnt[0]++; last[0] = edges; end
            if (step_y) begin cnt[1]++; last[1] = edges; end
            if (step_z) begin cnt[2]++; last[2] = edges; end
            if ({dir_z, dir_y, dir_x} != exp_dir) dir_bad = 1;
            if (!busy) busy_bad = 1;
            if (done) begin seen = 1; done_at = edges; end
            else begin @(posedge clk); edges++; end
        end
        start = 1'b0;
        check(cnt[0] == d[0], "R1 x step count", cnt[0], d[0]);
        check(cnt[1] == d[1], "R1 y step count", cnt[1], d[1]);
        check(cnt[2] == d[2], "R1 z step count", cnt[2], d[2]);
        check(!dir_bad, "R2 direction latched", dir_bad, 0);
        check(done_at == exp_edges, "R4 R5 R8 done edge", done_at, exp_edges);
        check(!busy_bad, "R6 busy through move", busy_bad, 0);
        for (int i = 0; i < 3; i++) begin
            if (d[i] > 0)
                check(last[i] == exp_edges - 1, "R3 common last step", last[i], exp_edges - 1);
        end
        @(negedge clk);
        check(!done && !busy, "R6 done one cycle, busy drops", {done, busy}, 0);
    endtask

    initial begin
        #(8 * 190000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        check({busy, done, step_x, step_y, step_z, dir_x, dir_y, dir_z} == 8'd0,
              "R9 outputs in reset", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, step_x, step_y, step_z, dir_x, dir_y, dir_z} == 8'd0,
              "R9 outputs after reset", {busy, done}, 0);

        // Vector table (R1 R2 R3 R4 R5 R6 R10)
        for (int v = 0; v < NVEC; v++) begin
            run_move(int'(VEC[v][111:96]), int'(VEC[v][95:80]), int'(VEC[v][79:64]),
                     int'(VEC[v][63:48]), int'(VEC[v][47:32]), int'(VEC[v][31:16]),
                     int'(VEC[v][15:0]), 1'b0);
        end

        // R8 zero-length move
        run_move(7, 7, 7, 7, 7, 7, 1000, 1'b0);

        // R7 start while busy is ignored
        run_move(0, 0, 0, 6, 2, 4, 1000, 1'b1);

        // R9 reset in the middle of a move
        @(negedge clk);
        x_from = 16'd0; y_from = 16'd0; z_from = 16'd0;
        x_to = 16'd20; y_to = 16'd20; z_to = 16'd20; feed = 16'd1000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        check(busy && dir_x, "R9 move running before reset", busy, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check({busy, done, step_x, step_y, step_z, dir_x, dir_y, dir_z} == 8'd0,
              "R9 mid-move reset clears outputs", {busy, dir_x}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule